// File: doc/BRIEF.md
# Hour-Minute Alarm Match Unit

This block watches the running hour and minute digits of a 12-hour clock. It compares them with an alarm time set on two static 8-bit switch banks, one bank for the hours and one for the minutes. Each bank holds two BCD nibbles, the tens digit in the upper nibble. The comparison is a plain equality test, one digit at a time. Seconds are not part of the comparison, so the alarm holds for the whole minute in which the hours and minutes match.

The equality result is registered into an indicator output. An enable input gates the buzzer output and leaves the comparison alone. The buzzer is high, which sounds it, only when the registered match and the enable are both true. Both outputs change only on the clock edge that follows a change of their inputs, so the ripple of the digit counters cannot reach them as glitches.

Top module: `alarm_match_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `alarm_ind` and `buzzer` are 0 after that edge.
- R2: When `hr_tens == set_hr[4]`, `hr_ones == set_hr[3:0]`, `min_tens == set_min[7:4]` and `min_ones == set_min[3:0]` at a rising edge, `alarm_ind` is 1 after that edge.
- R3: A mismatch in any single one of the four digits at a rising edge makes `alarm_ind` 0 after that edge.
- R4: Only bit 4 of `set_hr` takes part in the hour-tens comparison. Bits 7:5 of `set_hr` have no effect on either output.
- R5: `buzzer` after an edge equals the match at that edge AND `alarm_en` at that edge. It is never 1 while `alarm_ind` is 0.
- R6: `alarm_en` has no effect on `alarm_ind`.
- R7: While the digits and the settings stay unchanged, both outputs keep their values for as many cycles as the inputs stay unchanged, which lasts a full matching minute.
- R8: The outputs are registered. A change of the digits becomes visible exactly one rising edge later, including a match that lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alarm_en | input | 1 | Enables the buzzer output |
| hr_tens | input | 1 | Current hour tens digit (0 or 1) |
| hr_ones | input | 4 | Current hour ones digit, BCD |
| min_tens | input | 4 | Current minute tens digit, BCD |
| min_ones | input | 4 | Current minute ones digit, BCD |
| set_hr | input | 8 | Alarm hour bank: [4] tens bit, [3:0] ones digit, [7:5] ignored |
| set_min | input | 8 | Alarm minute bank: [7:4] tens digit, [3:0] ones digit |
| alarm_ind | output | 1 | Registered match indicator |
| buzzer | output | 1 | Registered, enabled alarm drive, 1 sounds |

## Verification
On every cycle the assertions check the one-edge relation between the digit comparison and the indicator, in both directions. They also check that the buzzer is off after a cycle with the enable low, that the buzzer never sounds without the indicator, that reset clears both outputs, and that unchanged inputs hold the outputs. The bench scenarios show what a single property cannot: a minute-by-minute sweep that crosses the alarm time, a mismatch in each digit on its own, all eight values of the ignored hour-bank bits, enable toggling during a match, one-cycle match pulses under random stimulus, and a reset that arrives in the middle of a match.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 4;
    localparam int BANK_W     = 2 * DIGIT_W;
    localparam int HR_LO_W    = DIGIT_W + 1;

    typedef enum logic [1:0] {
        DIG_MIN_ONES = 2'd0,
        DIG_MIN_TENS = 2'd1,
        DIG_HR_ONES  = 2'd2,
        DIG_HR_TENS  = 2'd3
    } digit_pos_e;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digit_vec_t;

    typedef struct packed {
        logic   hr_tens;
        digit_t hr_ones;
        digit_t min_tens;
        digit_t min_ones;
    } hm_time_t;

    typedef struct packed {
        logic ind;
        logic buzz;
    } alarm_out_t;

    function automatic hm_time_t decode_setting(input logic [HR_LO_W-1:0] hr_lo,
                                                input logic [BANK_W-1:0]  min_bank);
        hm_time_t t;
        t.hr_tens  = hr_lo[DIGIT_W];
        t.hr_ones  = hr_lo[DIGIT_W-1:0];
        t.min_tens = min_bank[BANK_W-1:DIGIT_W];
        t.min_ones = min_bank[DIGIT_W-1:0];
        return t;
    endfunction

    function automatic digit_vec_t to_digits(input hm_time_t t);
        digit_vec_t v;
        v[int'(DIG_HR_TENS)]  = {{(DIGIT_W-1){1'b0}}, t.hr_tens};
        v[int'(DIG_HR_ONES)]  = t.hr_ones;
        v[int'(DIG_MIN_TENS)] = t.min_tens;
        v[int'(DIG_MIN_ONES)] = t.min_ones;
        return v;
    endfunction

endpackage

// File: rtl/digit_cmp.sv
module digit_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    assign eq = (a == b);
endmodule

// File: rtl/match_core.sv
module match_core
    import alarm_match_pkg::*;
(
    input  hm_time_t now_t,
    input  hm_time_t alarm_t,
    output logic     all_eq
);
    digit_vec_t             lhs;
    digit_vec_t             rhs;
    logic [NUM_DIGITS-1:0]  eq_vec;

    assign lhs = to_digits(now_t);
    assign rhs = to_digits(alarm_t);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        digit_cmp #(.W(DIGIT_W)) u_cmp (
            .a  (lhs[g]),
            .b  (rhs[g]),
            .eq (eq_vec[g])
        );
    end

    assign all_eq = &eq_vec;
endmodule

// File: rtl/alarm_out_reg.sv
module alarm_out_reg
    import alarm_match_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match_i,
    input  logic enable_i,
    output logic ind_o,
    output logic buzz_o
);
    alarm_out_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.ind  <= match_i;
            q.buzz <= match_i & enable_i;
        end
    end

    assign ind_o  = q.ind;
    assign buzz_o = q.buzz;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_en,
    input  logic              hr_tens,
    input  logic [DIGIT_W-1:0] hr_ones,
    input  logic [DIGIT_W-1:0] min_tens,
    input  logic [DIGIT_W-1:0] min_ones,
    input  logic [BANK_W-1:0]  set_hr,
    input  logic [BANK_W-1:0]  set_min,
    output logic              alarm_ind,
    output logic              buzzer
);
    hm_time_t now_t;
    hm_time_t alarm_t;
    logic     match;
    logic     unused_hr_hi;

    assign now_t.hr_tens  = hr_tens;
    assign now_t.hr_ones  = hr_ones;
    assign now_t.min_tens = min_tens;
    assign now_t.min_ones = min_ones;

    assign alarm_t      = decode_setting(set_hr[HR_LO_W-1:0], set_min);
    assign unused_hr_hi = ^set_hr[BANK_W-1:HR_LO_W];

    match_core u_core (
        .now_t   (now_t),
        .alarm_t (alarm_t),
        .all_eq  (match)
    );

    alarm_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .match_i  (match),
        .enable_i (alarm_en),
        .ind_o    (alarm_ind),
        .buzz_o   (buzzer)
    );
endmodule

// File: rtl/alarm_match_sva.sv
module alarm_match_sva (
    input logic       clk,
    input logic       rst,
    input logic       alarm_en,
    input logic       hr_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [4:0] hr_set_lo,
    input logic [7:0] set_min,
    input logic       alarm_ind,
    input logic       buzzer
);
    logic hit;
    assign hit = (hr_tens == hr_set_lo[4]) && (hr_ones == hr_set_lo[3:0]) &&
                 (min_tens == set_min[7:4]) && (min_ones == set_min[3:0]);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!alarm_ind && !buzzer)); // R1

    AST_MATCH_SETS_IND: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_ind); // R2, R4

    AST_MISMATCH_CLEARS_IND: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !alarm_ind); // R3

    AST_BUZZ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !alarm_en |=> !buzzer); // R5

    AST_BUZZ_WITH_IND: assert property (@(posedge clk) disable iff (rst)
        buzzer |-> alarm_ind); // R5

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable({hr_tens, hr_ones, min_tens, min_ones, hr_set_lo, set_min, alarm_en}))
        |=> ($stable(alarm_ind) && $stable(buzzer))); // R7
endmodule

bind alarm_match_unit alarm_match_sva i_sva (
    .clk       (clk),
    .rst       (rst),
    .alarm_en  (alarm_en),
    .hr_tens   (hr_tens),
    .hr_ones   (hr_ones),
    .min_tens  (min_tens),
    .min_ones  (min_ones),
    .hr_set_lo (set_hr[4:0]),
    .set_min   (set_min),
    .alarm_ind (alarm_ind),
    .buzzer    (buzzer)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alarm_en = 1'b0;
    logic       hr_tens = 1'b0;
    logic [3:0] hr_ones = 4'd0;
    logic [3:0] min_tens = 4'd0;
    logic [3:0] min_ones = 4'd0;
    logic [7:0] set_hr = 8'h00;
    logic [7:0] set_min = 8'h00;
    logic       alarm_ind;
    logic       buzzer;

    int    vectors = 0;
    int    fails = 0;
    int    exp_ind = 0;
    int    exp_buz = 0;
    string phase = "R1";

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst(rst), .alarm_en(alarm_en),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
        .set_hr(set_hr), .set_min(set_min),
        .alarm_ind(alarm_ind), .buzzer(buzzer)
    );

    always #5 clk = ~clk;

    // Reference: digit-wise equality of the time against the two banks, one edge late.
    function automatic int ref_match();
        int ht_set = (int'(set_hr) >> 4) & 1;
        int ho_set = int'(set_hr) & 15;
        int mt_set = (int'(set_min) >> 4) & 15;
        int mo_set = int'(set_min) & 15;
        return (int'(hr_tens) == ht_set && int'(hr_ones) == ho_set &&
                int'(min_tens) == mt_set && int'(min_ones) == mo_set) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_ind = 0;
            exp_buz = 0;
        end else begin
            exp_ind = ref_match();
            exp_buz = (exp_ind == 1 && alarm_en) ? 1 : 0;
        end
    end

    task automatic step();
        @(negedge clk);
        vectors++;
        if (alarm_ind !== exp_ind[0]) begin
            fails++;
            $display("FAIL %s alarm_ind got %b expected %0d at %0t", phase, alarm_ind, exp_ind, $time);
        end
        if (buzzer !== exp_buz[0]) begin
            fails++;
            $display("FAIL %s buzzer got %b expected %0d at %0t", phase, buzzer, exp_buz, $time);
        end
    endtask

    task automatic set_time(input int h, input int m);
        hr_tens  = (h >= 10) ? 1'b1 : 1'b0;
        hr_ones  = 4'(h % 10);
        min_tens = 4'(m / 10);
        min_ones = 4'(m % 10);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired, expected run to end earlier");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset clears outputs even with a matching time present
        set_hr = 8'h07; set_min = 8'h45; alarm_en = 1'b1; set_time(7, 45);
        @(negedge clk);
        step(); step();
        rst = 1'b0;

        // R2 / R7: sweep minutes across the alarm, holding each minute for several cycles
        phase = "R2/R7";
        for (int m = 40; m <= 50; m++) begin
            set_time(7, m);
            for (int k = 0; k < 4; k++) step();
        end

        // R3: break each digit on its own while the others match
        phase = "R3";
        set_time(7, 45); step(); step();
        hr_ones = 4'd8;  step(); step(); hr_ones = 4'd7;  step();
        min_tens = 4'd5; step(); step(); min_tens = 4'd4; step();
        min_ones = 4'd4; step(); step(); min_ones = 4'd5; step();
        hr_tens = 1'b1;  step(); step(); hr_tens = 1'b0;  step();

        // R4: upper hour-bank bits ignored, bit 4 is the hour tens
        phase = "R4";
        set_time(12, 30); set_min = 8'h30;
        for (int u = 0; u < 8; u++) begin
            set_hr = {3'(u), 1'b1, 4'h2}; step(); step();
        end
        for (int u = 0; u < 8; u++) begin
            set_hr = {3'(u), 1'b0, 4'h2}; step(); step();
        end

        // R5 / R6: enable toggles during a match; indicator unaffected
        phase = "R5/R6";
        set_hr = 8'h12;
        for (int k = 0; k < 8; k++) begin
            alarm_en = (k % 2 == 0) ? 1'b0 : 1'b1; step();
        end
        alarm_en = 1'b0; step(); step(); step();
        alarm_en = 1'b1; step(); step();

        // R8: one-cycle match pulses and random digit traffic near the alarm time
        phase = "R8";
        set_hr = 8'h01; set_min = 8'h23;
        for (int k = 0; k < 400; k++) begin
            hr_tens  = 1'($urandom_range(0, 1));
            hr_ones  = 4'($urandom_range(0, 2));
            min_tens = 4'($urandom_range(1, 3));
            min_ones = 4'($urandom_range(2, 4));
            alarm_en = 1'($urandom_range(0, 1));
            if (k % 37 == 0) set_hr[7:5] = 3'($urandom_range(0, 7));
            step();
        end

        // R1: reset arriving in the middle of a match
        phase = "R1";
        set_hr = 8'h01; set_min = 8'h23; set_time(1, 23); alarm_en = 1'b1;
        step(); step();
        rst = 1'b1; step(); step();
        rst = 1'b0; step(); step();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule